// File: doc/BRIEF.md
# Windowed Write-Once Watchdog Timer

This block is a watchdog for a system controller. A 12-bit count runs down by one for every `PRESCALE` pulses of a slow-clock enable. Software has to refresh it with a keyed command before it passes zero. If the count expires, or if a refresh arrives too early, the block raises a one-cycle reset request, a one-cycle interrupt, or both, and records the cause in sticky status flags.

The configuration word sets the timeout, the refresh window, the output enables, the debug freeze and the disable. It is accepted only once after reset. After that the block is fixed until the next reset, so runaway code cannot switch the watchdog off. A refresh is accepted only while the current count is at or below the window value. Reading the status clears the sticky flags. The status word also reports the live count and whether the configuration is locked.

Top module: `wdog_top`

## Requirements
- R1: After reset the count is 0xFFF, both sticky flags and the lock flag are 0, and `rst_req` and `irq` are low. The configuration in force is: enabled, timeout 0xFFF, window 0xFFF, reset enable on, interrupt off, debug freeze off. The status word on `rd_data` carries the underflow flag in bit 0, the window-error flag in bit 1, the lock flag in bit 2 and the count in bits 27:16.
- R2: While enabled and not frozen, the count falls by one after every `PRESCALE` cycles in which `slow_tick` is high. Cycles with `slow_tick` low do not advance it.
- R3: A configuration write is `wr_en` with `wr_sel`=0. Only the first one after reset is taken, and it sets the lock flag. Every later one is ignored, including one that sets the disable bit.
- R4: With the disable bit (configuration bit 27) set, the count holds, refresh commands are ignored, and no flag or output pulse is raised.
- R5: When a prescaler step finds the count at 0, the count reloads from the timeout (bits 11:0) and keeps running. The underflow flag is set. If reset enable (bit 24) is on, `rst_req` is high for exactly the next cycle.
- R6: Any fault (an expiry or a window error) pulses `irq` for one cycle when interrupt enable (bit 25) is on. With reset enable off, the fault does not pulse `rst_req`.
- R7: With debug freeze (bit 26) on and `dbg_halt` high, the count and the prescaler hold.
- R8: A refresh is `wr_en` with `wr_sel`=1, `wr_data[31:24]`=0xA5 and `wr_data[0]`=1. When the count is at or below the window (bits 23:12), it reloads the count from the timeout and restarts the prescaler phase.
- R9: A refresh while the count is above the window leaves the count alone. It sets the window-error flag and, if reset enable is on, pulses `rst_req` for one cycle.
- R10: A control write whose key is not 0xA5 has no effect.
- R11: A cycle with `rd_en` high clears both sticky flags, unless a new event sets one of them in the same cycle.
- R12: The accepted configuration write loads the count from its new timeout and restarts the prescaler phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| slow_tick | input | 1 | One-cycle enable per slow-clock period |
| dbg_halt | input | 1 | Debugger halt indication |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | 0 selects configuration, 1 selects control |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Status read strobe, clears the sticky flags |
| rd_data | output | 32 | Status word: flags, lock, live count |
| rst_req | output | 1 | One-cycle reset request |
| irq | output | 1 | One-cycle interrupt pulse |

## Verification
The live count is visible in the status word on every cycle. A wrong prescaler phase, a missed reload or a lost freeze therefore shows up as a count mismatch within one prescaler period. A wrong lock or window decision shows up on the cycle after the write: as a flag in the status word, or as a pulse on `rst_req` or `irq` that should or should not be there. A reference model in the bench tracks the count, the flags and both pulse outputs through random traffic, so any divergence is reported on the cycle it first becomes visible.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
   localparam int CNT_W = 12;

   typedef struct packed {
      logic             dis;
      logic             halt_en;
      logic             irq_en;
      logic             rst_en;
      logic [CNT_W-1:0] delta;
      logic [CNT_W-1:0] tmo;
   } wd_mode_t;

   localparam int MODE_W = $bits(wd_mode_t);

   localparam wd_mode_t MODE_RST = '{dis: 1'b0, halt_en: 1'b0, irq_en: 1'b0,
                                     rst_en: 1'b1, delta: '1, tmo: '1};
endpackage

// File: rtl/wdog_cfg.sv
module wdog_cfg
   import wdog_pkg::*;
#(
   parameter int          DATA_W = 32,
   parameter int          KEY_W  = 8,
   parameter logic [7:0]  KEY    = 8'hA5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              wr_sel,
   input  logic [DATA_W-1:0] wr_data,
   output wd_mode_t          mode,
   output logic              locked,
   output logic              mode_wr,
   output logic              restart
);
   localparam int KEY_LSB = DATA_W - KEY_W;

   assign mode_wr = wr_en && !wr_sel && !locked;
   assign restart = wr_en && wr_sel && wr_data[0] &&
                    (wr_data[DATA_W-1:KEY_LSB] == KEY[KEY_W-1:0]);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode   <= MODE_RST;
         locked <= 1'b0;
      end else if (mode_wr) begin
         mode   <= wd_mode_t'(wr_data[MODE_W-1:0]);
         locked <= 1'b1;
      end
   end

   AST_LOCK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (locked && wr_en && !wr_sel) |=> $stable(mode)); // R3
endmodule

// File: rtl/wdog_presc.sv
module wdog_presc #(
   parameter int PRESCALE = 128
) (
   input  logic clk,
   input  logic rst_n,
   input  logic slow_tick,
   input  logic run,
   input  logic clr,
   output logic tick
);
   localparam int PW = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
   localparam logic [PW-1:0] LAST = PW'(PRESCALE - 1);

   generate
      if (PRESCALE == 1) begin : g_direct
         logic unused_clr;
         assign unused_clr = clr;
         assign tick       = slow_tick && run;
      end else begin : g_div
         logic [PW-1:0] pre;
         assign tick = slow_tick && run && (pre == LAST);
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                 pre <= '0;
            else if (clr)               pre <= '0;
            else if (slow_tick && run)  pre <= (pre == LAST) ? '0 : pre + 1'b1;
         end

         AST_HALT_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
            (!run && !clr) |=> $stable(pre)); // R7
      end
   endgenerate
endmodule

// File: rtl/wdog_cnt.sv
module wdog_cnt
   import wdog_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             load,
   input  logic [CNT_W-1:0] tmo,
   output logic [CNT_W-1:0] cnt,
   output logic             expire
);
   assign expire = tick && !load && (cnt == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)               cnt <= '1;
      else if (load || expire)  cnt <= tmo;
      else if (tick)            cnt <= cnt - 1'b1;
   end

   AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !load && cnt != '0) |=> (cnt == $past(cnt) - 1'b1)); // R2
   AST_RELOAD_ON_EXPIRE: assert property (@(posedge clk) disable iff (!rst_n)
      expire |=> (cnt == $past(tmo))); // R5
endmodule

// File: rtl/wdog_top.sv
module wdog_top
   import wdog_pkg::*;
#(
   parameter int         PRESCALE = 128,
   parameter int         DATA_W   = 32,
   parameter int         KEY_W    = 8,
   parameter logic [7:0] KEY      = 8'hA5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              slow_tick,
   input  logic              dbg_halt,
   input  logic              wr_en,
   input  logic              wr_sel,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              rd_en,
   output logic [DATA_W-1:0] rd_data,
   output logic              rst_req,
   output logic              irq
);
   localparam int CNT_LSB = 16;
   localparam int PAD_HI  = DATA_W - CNT_LSB - CNT_W;
   localparam int PAD_LO  = CNT_LSB - 3;

   generate
      if (PRESCALE < 1)       begin : g_bad_presc $error("PRESCALE must be at least 1"); end
      if (KEY_W < 1 || KEY_W > 8) begin : g_bad_key $error("KEY_W must be 1..8"); end
      if (DATA_W < CNT_LSB + CNT_W || DATA_W < MODE_W)
                              begin : g_bad_dw $error("DATA_W too small for the fields"); end
   endgenerate

   wd_mode_t         mode;
   logic             locked, mode_wr, restart;
   logic             run, tick, load, restart_ok, win_ok, werr_ev, expire, fault;
   logic [CNT_W-1:0] cnt;
   logic             uf_flag, werr_flag;

   wdog_cfg #(.DATA_W(DATA_W), .KEY_W(KEY_W), .KEY(KEY)) i_cfg (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
      .mode(mode), .locked(locked), .mode_wr(mode_wr), .restart(restart));

   assign run        = !mode.dis && !(mode.halt_en && dbg_halt);
   assign restart_ok = restart && !mode.dis;
   assign win_ok     = (cnt <= mode.delta);
   assign load       = mode_wr || (restart_ok && win_ok);
   assign werr_ev    = restart_ok && !win_ok;

   wdog_presc #(.PRESCALE(PRESCALE)) i_presc (
      .clk(clk), .rst_n(rst_n), .slow_tick(slow_tick), .run(run), .clr(load), .tick(tick));

   wdog_cnt i_cnt (
      .clk(clk), .rst_n(rst_n), .tick(tick), .load(load), .tmo(mode_wr ? wr_data[CNT_W-1:0] : mode.tmo),
      .cnt(cnt), .expire(expire));

   assign fault = expire || werr_ev;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         uf_flag   <= 1'b0;
         werr_flag <= 1'b0;
         rst_req   <= 1'b0;
         irq       <= 1'b0;
      end else begin
         if (rd_en) begin
            uf_flag   <= 1'b0;
            werr_flag <= 1'b0;
         end
         if (expire)  uf_flag   <= 1'b1;
         if (werr_ev) werr_flag <= 1'b1;
         rst_req <= fault && mode.rst_en;
         irq     <= fault && mode.irq_en;
      end
   end

   assign rd_data = {{PAD_HI{1'b0}}, cnt, {PAD_LO{1'b0}}, locked, werr_flag, uf_flag};

   AST_DIS_NO_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
      mode.dis |-> !fault); // R4
   AST_FLAG_READ: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && !fault) |=> (!uf_flag && !werr_flag)); // R11
   AST_EARLY_NO_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (werr_ev && !tick) |=> $stable(cnt)); // R9
   AST_WRITE_LOCKS: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !wr_sel) |=> locked); // R3
endmodule

// File: tb/test_wdog_top.sv
module test_wdog_top;
   localparam int P = 4;
   localparam logic [31:0] CMD_OK = {8'hA5, 23'd0, 1'b1};

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        slow_tick = 1'b0, dbg_halt = 1'b0;
   logic        wr_en = 1'b0, wr_sel = 1'b0, rd_en = 1'b0;
   logic [31:0] wr_data = '0;
   logic [31:0] rd_data;
   logic        rst_req, irq;

   int tests = 0;
   int fails = 0;
   int cycles = 0;

   always #2 clk = ~clk;

   wdog_top #(.PRESCALE(P)) i_wdog_top (
      .clk(clk), .rst_n(rst_n), .slow_tick(slow_tick), .dbg_halt(dbg_halt),
      .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data), .rd_en(rd_en),
      .rd_data(rd_data), .rst_req(rst_req), .irq(irq));

   // Reference model built from the requirements
   logic [11:0] m_tmo, m_dlt, m_cnt;
   logic        m_rst, m_irq, m_halt, m_dis, m_lock, m_uf, m_we, m_rq, m_iq;
   int          m_pre;

   function automatic logic [31:0] exp_status();
      return {4'd0, m_cnt, 13'd0, m_lock, m_we, m_uf};
   endfunction

   function automatic logic [31:0] mk_mode(input logic dis, halt, ien, ren,
                                          input logic [11:0] dlt, tmo);
      return {4'd0, dis, halt, ien, ren, dlt, tmo};
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_tmo = 12'hFFF; m_dlt = 12'hFFF; m_cnt = 12'hFFF;
         m_rst = 1'b1; m_irq = 1'b0; m_halt = 1'b0; m_dis = 1'b0;
         m_lock = 1'b0; m_uf = 1'b0; m_we = 1'b0; m_rq = 1'b0; m_iq = 1'b0; m_pre = 0;
      end else begin
         logic ok_cmd, ev_uf, ev_we;
         ev_uf = 1'b0; ev_we = 1'b0;
         ok_cmd = wr_en && wr_sel && wr_data[31:24] == 8'hA5 && wr_data[0] && !m_dis;
         if (wr_en && !wr_sel && !m_lock) begin
            m_dis = wr_data[27]; m_halt = wr_data[26]; m_irq_tmp(wr_data);
         end else if (ok_cmd && m_cnt <= m_dlt) begin
            m_cnt = m_tmo; m_pre = 0;
         end else begin
            if (ok_cmd) ev_we = 1'b1;
            if (slow_tick && !m_dis && !(m_halt && dbg_halt)) begin
               if (m_pre == P - 1) begin
                  m_pre = 0;
                  if (m_cnt == 0) begin m_cnt = m_tmo; ev_uf = 1'b1; end
                  else m_cnt = m_cnt - 1'b1;
               end else m_pre = m_pre + 1;
            end
         end
         if (rd_en) begin m_uf = 1'b0; m_we = 1'b0; end
         if (ev_uf) m_uf = 1'b1;
         if (ev_we) m_we = 1'b1;
         m_rq = (ev_uf || ev_we) && m_rst;
         m_iq = (ev_uf || ev_we) && m_irq;
         if (wr_en && !wr_sel && !m_lock) m_lock = 1'b1;
      end
   end

   task automatic m_irq_tmp(input logic [31:0] d);
      // accepted configuration write: R12 reload, R3 lock
      m_irq = d[25]; m_rst = d[24]; m_dlt = d[23:12]; m_tmo = d[11:0];
      m_cnt = d[11:0]; m_pre = 0;
   endtask

   task automatic chk(input logic ok, input string tag, input logic [31:0] act, exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   logic cmp_en = 1'b0;
   always @(negedge clk) begin
      if (rst_n && cmp_en) begin
         chk(rd_data == exp_status(), "R2 R5 R8 R9 model status", rd_data, exp_status());
         chk(rst_req == m_rq, "R5 R9 model rst_req", 32'(rst_req), 32'(m_rq));
         chk(irq == m_iq, "R6 model irq", 32'(irq), 32'(m_iq));
      end
   end

   task automatic summary();
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles == 150000) begin
         tests++; fails++;
         $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
         summary();
         $finish;
      end
   end

   task automatic cyc(input int n);
      repeat (n) begin @(posedge clk); @(negedge clk); #1; end
   endtask

   task automatic wr(input logic sel, input logic [31:0] d);
      wr_en = 1'b1; wr_sel = sel; wr_data = d;
      cyc(1);
      wr_en = 1'b0; wr_data = '0;
   endtask

   task automatic do_reset();
      rst_n = 1'b0; cyc(2); rst_n = 1'b1;
   endtask

   initial begin
      logic seen_rst, seen_irq;
      void'($urandom(32'd2024));
      cyc(2); rst_n = 1'b1; #1;
      cmp_en = 1'b1;
      // R1 reset state
      chk(rd_data == 32'h0FFF_0000, "R1 reset status", rd_data, 32'h0FFF_0000);
      chk(!rst_req && !irq, "R1 outputs low", {30'd0, rst_req, irq}, 32'd0);

      slow_tick = 1'b1;
      wr(1'b0, mk_mode(0, 0, 1, 1, 12'd2, 12'd5));
      chk(rd_data == 32'h0005_0004, "R12 load on config", rd_data, 32'h0005_0004);
      wr(1'b0, mk_mode(1, 0, 0, 0, 12'hFFF, 12'd9));
      cyc(3);
      chk(rd_data == 32'h0004_0004, "R3 second write ignored", rd_data, 32'h0004_0004);
      slow_tick = 1'b0;
      cyc(10);
      chk(rd_data[27:16] == 12'd4, "R2 no slow tick no step", 32'(rd_data[27:16]), 32'd4);
      wr(1'b1, {8'h5A, 23'd0, 1'b1});
      chk(rd_data == 32'h0004_0004 && !rst_req, "R10 bad key", rd_data, 32'h0004_0004);
      wr(1'b1, CMD_OK);
      chk(rd_data == 32'h0004_0006, "R9 early refresh flag", rd_data, 32'h0004_0006);
      chk(rst_req && irq, "R9 early refresh pulse", {30'd0, rst_req, irq}, 32'd3);
      cyc(1);
      chk(!rst_req, "R9 pulse one cycle", 32'(rst_req), 32'd0);
      rd_en = 1'b1; cyc(1); rd_en = 1'b0;
      chk(rd_data == 32'h0004_0004, "R11 read clears", rd_data, 32'h0004_0004);
      slow_tick = 1'b1;
      cyc(8);
      chk(rd_data[27:16] == 12'd2, "R2 step per prescale", 32'(rd_data[27:16]), 32'd2);
      wr(1'b1, CMD_OK);
      chk(rd_data == 32'h0005_0004 && !rst_req, "R8 refresh in window", rd_data, 32'h0005_0004);
      cyc(23);
      chk(rd_data[27:16] == 12'd0 && !rst_req, "R5 count at zero", rd_data, 32'h0000_0004);
      cyc(1);
      chk(rd_data == 32'h0005_0005, "R5 expiry reload and flag", rd_data, 32'h0005_0005);
      chk(rst_req && irq, "R5 R6 expiry pulses", {30'd0, rst_req, irq}, 32'd3);
      cyc(1);
      chk(!rst_req && !irq, "R5 single cycle pulse", {30'd0, rst_req, irq}, 32'd0);

      // debug freeze with interrupt only
      do_reset();
      wr(1'b0, mk_mode(0, 1, 1, 0, 12'hFFF, 12'd10));
      dbg_halt = 1'b1; cyc(20);
      chk(rd_data[27:16] == 12'd10, "R7 frozen", 32'(rd_data[27:16]), 32'd10);
      dbg_halt = 1'b0; cyc(4);
      chk(rd_data[27:16] == 12'd9, "R7 resumes", 32'(rd_data[27:16]), 32'd9);
      seen_rst = 1'b0; seen_irq = 1'b0;
      for (int i = 0; i < 40; i++) begin
         cyc(1);
         seen_rst |= rst_req; seen_irq |= irq;
      end
      chk(seen_irq && !seen_rst, "R6 irq without reset", {30'd0, seen_rst, seen_irq}, 32'd1);

      // disabled
      do_reset();
      wr(1'b0, mk_mode(1, 0, 1, 1, 12'hFFF, 12'd1));
      seen_rst = 1'b0; seen_irq = 1'b0;
      for (int i = 0; i < 40; i++) begin
         if (i % 8 == 0) wr(1'b1, CMD_OK); else cyc(1);
         seen_rst |= rst_req; seen_irq |= irq;
      end
      chk(rd_data == 32'h0001_0004 && !seen_rst && !seen_irq, "R4 disabled holds",
          rd_data, 32'h0001_0004);

      // random traffic against the model
      do_reset();
      for (int i = 0; i < 5000; i++) begin
         int r;
         r = int'($urandom % 100);
         rst_n = !(r < 2);
         slow_tick = ($urandom % 4) != 0;
         dbg_halt = ($urandom % 3) == 0;
         rd_en = (r >= 20 && r < 26);
         wr_en = (r >= 2 && r < 20);
         wr_sel = (r >= 6);
         if (r >= 2 && r < 6)
            wr_data = mk_mode(($urandom % 8) == 0, 1'($urandom), 1'($urandom), 1'($urandom),
                              ($urandom % 2) ? 12'hFFF : 12'($urandom % 16), 12'($urandom % 16));
         else
            wr_data = {(($urandom % 5) == 0) ? 8'($urandom) : 8'hA5, 23'($urandom), 1'($urandom % 4 != 0)};
         cyc(1);
      end
      rst_n = 1'b1; wr_en = 1'b0; rd_en = 1'b0;
      cyc(2);
      summary();
      $finish;
   end
endmodule